// File: doc/BRIEF.md
# Fault Excitation and Masking Monitor

This block watches a run in which a fault-free copy and a faulty copy of a small circuit get the same stimulus. One fault is selected by a kind code. For that fault the block evaluates an activation condition over the internal signals that the fault touches. These signals are the input vector of a look-up table, or the two routing inputs A and C of a switch pair. The block also compares the two copies' output buses on every clock cycle.

Two sticky flags record that the fault was excited and that it became visible at the outputs. Each flag has a timestamp that holds the cycle count at its first occurrence. A pulse at the end of a run sets a masked status when the fault was activated but never reached the outputs. A synchronous clear starts a new run.

Top module: `fault_watch`

## Requirements
- R1: With kind code 0 (table-bit fault), the fault is excited in a cycle where `lut_vec` equals `lut_target`. A vector that differs in any bit does not excite it.
- R2: With kind code 1 (stuck-at-0), the fault is excited when `route_a` is 1. With kind code 2 (stuck-at-1), it is excited when `route_a` is 0. `route_c` is ignored for both codes.
- R3: With kind code 3 (bridge), the fault is excited when `route_a` differs from `route_c`.
- R4: With kind code 4 (wired-AND), the fault is excited when A differs from A AND C, or C differs from A AND C. Kind code 5 (wired-OR) applies the same rule with OR. Kind codes 6 and 7 never excite.
- R5: If `golden_out` and `faulty_out` differ in any bit at a clock edge, `observed` is 1 from the next cycle on.
- R6: `excited` rises in the cycle after the first excitation. `excited` and `observed` stay at 1 until `clear` or `rst`.
- R7: `exc_cycle` and `obs_cycle` capture the cycle count of the first excitation and the first observation. Later events do not change them until a clear.
- R8: A cycle with `clear` high returns both flags, both stamps, `masked` and the counter to 0. This holds even when an excitation, a mismatch or `run_end` occurs in that same cycle.
- R9: The cycle counter reads 0 in the first cycle after a reset or clear. It then advances by one per cycle and saturates at its maximum value.
- R10: A cycle with `run_end` high sets `masked` to (fault excited, including that cycle) AND NOT (fault observed, including that cycle). The value is held until the next `run_end`, clear or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Starts a new run; clears flags, stamps, masked status and counter |
| run_end | input | 1 | Marks the last cycle of a run; updates `masked` |
| fault_kind | input | 3 | Fault model code (0 to 5 valid) |
| lut_target | input | LUT_INPUTS | Table input vector that addresses the flipped bit |
| lut_vec | input | LUT_INPUTS | Live input vector of the monitored table |
| route_a | input | 1 | Routing input A |
| route_c | input | 1 | Routing input C |
| golden_out | input | OUT_W | Output pins of the fault-free copy |
| faulty_out | input | OUT_W | Output pins of the faulty copy |
| excited | output | 1 | Sticky: the fault's activating condition has occurred |
| observed | output | 1 | Sticky: the outputs of the two copies have differed |
| masked | output | 1 | Excited but not observed at the last run end |
| exc_cycle | output | CNT_W | Cycle count at the first excitation |
| obs_cycle | output | CNT_W | Cycle count at the first observation |

## Verification
Several functions of the block can fall in the same cycle. The bench applies a clear together with an excitation and an output mismatch in one cycle, and then expects every flag and stamp at zero on both that cycle and the next. It applies the first excitation and the first mismatch in one cycle, and expects both flags and two identical stamps. It raises `run_end` in the cycle of an excitation, with and without a mismatch. `masked` must then follow the events of that cycle as well as those already recorded.

// File: rtl/fw_pkg.sv
package fw_pkg;

    typedef enum logic [2:0] {
        FK_LUT_BIT   = 3'd0,
        FK_STUCK0    = 3'd1,
        FK_STUCK1    = 3'd2,
        FK_BRIDGE    = 3'd3,
        FK_WIRED_AND = 3'd4,
        FK_WIRED_OR  = 3'd5
    } fault_kind_e;

    typedef struct packed {
        logic a;
        logic c;
    } route_pair_t;

    localparam int EV_EXCITE  = 0;
    localparam int EV_OBSERVE = 1;
    localparam int EV_COUNT   = 2;

    // A wired fault is active when either input differs from the merged value.
    function automatic logic wired_active(logic a, logic c, logic use_or);
        logic merged;
        merged = use_or ? (a | c) : (a & c);
        return (a != merged) || (c != merged);
    endfunction

endpackage

// File: rtl/fw_excite_cond.sv
module fw_excite_cond
    import fw_pkg::*;
#(
    parameter int LUT_INPUTS = 4
) (
    input  logic [2:0]            kind,
    input  logic [LUT_INPUTS-1:0] lut_target,
    input  logic [LUT_INPUTS-1:0] lut_vec,
    input  route_pair_t           route,
    output logic                  hit
);
    always_comb begin
        case (fault_kind_e'(kind))
            FK_LUT_BIT:   hit = (lut_vec == lut_target);
            FK_STUCK0:    hit = route.a;
            FK_STUCK1:    hit = ~route.a;
            FK_BRIDGE:    hit = route.a ^ route.c;
            FK_WIRED_AND: hit = wired_active(route.a, route.c, 1'b0);
            FK_WIRED_OR:  hit = wired_active(route.a, route.c, 1'b1);
            default:      hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/fw_mismatch.sv
module fw_mismatch #(
    parameter int OUT_W = 4
) (
    input  logic [OUT_W-1:0] golden,
    input  logic [OUT_W-1:0] faulty,
    output logic             hit
);
    logic [OUT_W-1:0] diff;

    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        assign diff[i] = golden[i] ^ faulty[i];
    end

    assign hit = |diff;
endmodule

// File: rtl/fw_cycle_count.sv
module fw_cycle_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clear)
            count <= '0;
        else if (count != CNT_MAX)
            count <= count + CNT_W'(1);
    end

    // R9: the counter steps by one per cycle until it saturates
    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        (!clear && count != CNT_MAX) |=> count == $past(count) + CNT_W'(1));
endmodule

// File: rtl/fw_event_stamp.sv
module fw_event_stamp #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             hit,
    input  logic [CNT_W-1:0] count,
    output logic             flag,
    output logic [CNT_W-1:0] stamp
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            flag  <= 1'b0;
            stamp <= '0;
        end else if (hit && !flag) begin
            flag  <= 1'b1;
            stamp <= count;
        end
    end

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clear) |=> flag);

    a_r7_stamp_hold: assert property (@(posedge clk) disable iff (rst)
        (flag && !clear) |=> $stable(stamp));
endmodule

// File: rtl/fault_watch.sv
module fault_watch
    import fw_pkg::*;
#(
    parameter int LUT_INPUTS = 4,
    parameter int OUT_W      = 4,
    parameter int CNT_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  run_end,
    input  logic [2:0]            fault_kind,
    input  logic [LUT_INPUTS-1:0] lut_target,
    input  logic [LUT_INPUTS-1:0] lut_vec,
    input  logic                  route_a,
    input  logic                  route_c,
    input  logic [OUT_W-1:0]      golden_out,
    input  logic [OUT_W-1:0]      faulty_out,
    output logic                  excited,
    output logic                  observed,
    output logic                  masked,
    output logic [CNT_W-1:0]      exc_cycle,
    output logic [CNT_W-1:0]      obs_cycle
);
    logic [EV_COUNT-1:0] ev_hit;
    logic [EV_COUNT-1:0] ev_flag;
    logic [CNT_W-1:0]    ev_stamp [EV_COUNT];
    logic [CNT_W-1:0]    cycle_now;
    route_pair_t         route;

    assign route = '{a: route_a, c: route_c};

    fw_excite_cond #(.LUT_INPUTS(LUT_INPUTS)) u_cond (
        .kind       (fault_kind),
        .lut_target (lut_target),
        .lut_vec    (lut_vec),
        .route      (route),
        .hit        (ev_hit[EV_EXCITE])
    );

    fw_mismatch #(.OUT_W(OUT_W)) u_cmp (
        .golden (golden_out),
        .faulty (faulty_out),
        .hit    (ev_hit[EV_OBSERVE])
    );

    fw_cycle_count #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .count (cycle_now)
    );

    for (genvar e = 0; e < EV_COUNT; e++) begin : g_ev
        fw_event_stamp #(.CNT_W(CNT_W)) u_stamp (
            .clk   (clk),
            .rst   (rst),
            .clear (clear),
            .hit   (ev_hit[e]),
            .count (cycle_now),
            .flag  (ev_flag[e]),
            .stamp (ev_stamp[e])
        );
    end

    assign excited   = ev_flag[EV_EXCITE];
    assign observed  = ev_flag[EV_OBSERVE];
    assign exc_cycle = ev_stamp[EV_EXCITE];
    assign obs_cycle = ev_stamp[EV_OBSERVE];

    always_ff @(posedge clk) begin
        if (rst || clear)
            masked <= 1'b0;
        else if (run_end)
            masked <= (excited | ev_hit[EV_EXCITE]) & ~(observed | ev_hit[EV_OBSERVE]);
    end

    a_r5_mismatch_seen: assert property (@(posedge clk) disable iff (rst)
        (golden_out != faulty_out && !clear) |=> observed);

    a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!excited && !observed && !masked && exc_cycle == '0 && obs_cycle == '0));

    a_r10_masked_needs_excited: assert property (@(posedge clk) disable iff (rst)
        masked |-> excited);
endmodule

// File: tb/fault_watch_tb_top.sv
module fault_watch_tb_top;
    localparam int LI = 4;
    localparam int OW = 4;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst, clr, rend, ra, rc;
    logic [2:0]    kind;
    logic [LI-1:0] tgt, vec;
    logic [OW-1:0] gold, bad;
    logic          excited, observed, masked;
    logic [CW-1:0] exc_cycle, obs_cycle;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fault_watch #(.LUT_INPUTS(LI), .OUT_W(OW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .clear(clr), .run_end(rend),
        .fault_kind(kind), .lut_target(tgt), .lut_vec(vec),
        .route_a(ra), .route_c(rc), .golden_out(gold), .faulty_out(bad),
        .excited(excited), .observed(observed), .masked(masked),
        .exc_cycle(exc_cycle), .obs_cycle(obs_cycle)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic no_mismatch();
        gold = 4'h6;
        bad  = 4'h6;
    endtask

    // Starts a new run with the given kind; the caller has set quiet inputs.
    task automatic new_run(input logic [2:0] k);
        kind = k;
        no_mismatch();
        rend = 1'b0;
        clr  = 1'b1;
        tick();
        clr  = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8", "excited after reset", excited, 0);
        chk("R8", "observed after reset", observed, 0);
        chk("R8", "masked after reset", masked, 0);
        chk("R8", "exc_cycle after reset", exc_cycle, 0);
    endtask

    task automatic t_lut();
        tgt = 4'hA;
        vec = 4'h5;
        new_run(3'd0);
        idle(2);
        vec = 4'hB;
        tick();
        chk("R1", "one-bit-off vector", excited, 0);
        vec = 4'hA;
        tick();
        vec = 4'h5;
        chk("R1", "matching vector", excited, 1);
        chk("R7", "lut stamp", exc_cycle, 3);
    endtask

    task automatic t_stuck();
        ra = 1'b0;
        rc = 1'b1;
        new_run(3'd1);
        tick();
        chk("R2", "sa0 with A=0", excited, 0);
        ra = 1'b1;
        rc = 1'b0;
        tick();
        chk("R2", "sa0 with A=1", excited, 1);
        ra = 1'b1;
        rc = 1'b0;
        new_run(3'd2);
        tick();
        chk("R2", "sa1 with A=1", excited, 0);
        ra = 1'b0;
        rc = 1'b1;
        tick();
        chk("R2", "sa1 with A=0", excited, 1);
    endtask

    task automatic t_bridge();
        ra = 1'b1;
        rc = 1'b1;
        new_run(3'd3);
        tick();
        chk("R3", "bridge A==C", excited, 0);
        rc = 1'b0;
        tick();
        chk("R3", "bridge A!=C", excited, 1);
    endtask

    task automatic t_wired();
        ra = 1'b0;
        rc = 1'b0;
        new_run(3'd4);
        tick();
        chk("R4", "wired-AND both 0", excited, 0);
        rc = 1'b1;
        tick();
        chk("R4", "wired-AND A=0 C=1", excited, 1);
        ra = 1'b1;
        rc = 1'b1;
        new_run(3'd5);
        tick();
        chk("R4", "wired-OR both 1", excited, 0);
        rc = 1'b0;
        tick();
        chk("R4", "wired-OR A=1 C=0", excited, 1);
        ra = 1'b1;
        rc = 1'b0;
        tgt = 4'h0;
        vec = 4'h0;
        new_run(3'd7);
        idle(2);
        chk("R4", "kind 7 never excites", excited, 0);
    endtask

    task automatic t_observe_sticky();
        ra = 1'b0;
        rc = 1'b0;
        new_run(3'd3);
        idle(4);
        chk("R5", "no mismatch", observed, 0);
        bad = 4'hE;
        tick();
        no_mismatch();
        chk("R5", "bit-3 mismatch seen", observed, 1);
        chk("R7", "obs stamp", obs_cycle, 4);
        rc = 1'b1;
        tick();
        rc = 1'b0;
        chk("R7", "exc stamp", exc_cycle, 5);
        idle(3);
        chk("R6", "excited held", excited, 1);
        chk("R6", "observed held", observed, 1);
        rc = 1'b1;
        bad = 4'h7;
        tick();
        rc = 1'b0;
        no_mismatch();
        chk("R7", "exc stamp kept", exc_cycle, 5);
        chk("R7", "obs stamp kept", obs_cycle, 4);
    endtask

    task automatic t_clear_collide();
        ra = 1'b0;
        rc = 1'b0;
        new_run(3'd3);
        rc = 1'b1;
        tick();
        chk("R8", "setup excited", excited, 1);
        rend = 1'b1;
        clr  = 1'b1;
        bad  = 4'h0;
        tick();
        clr  = 1'b0;
        rend = 1'b0;
        rc   = 1'b0;
        no_mismatch();
        chk("R8", "clear beats excite", excited, 0);
        chk("R8", "clear beats mismatch", observed, 0);
        chk("R8", "clear beats run end", masked, 0);
        chk("R8", "stamp zeroed", exc_cycle, 0);
        tick();
        chk("R8", "no late excite", excited, 0);
        chk("R8", "no late observe", observed, 0);
    endtask

    task automatic t_same_cycle();
        ra = 1'b0;
        rc = 1'b0;
        new_run(3'd3);
        idle(2);
        rc  = 1'b1;
        bad = 4'h1;
        tick();
        rc = 1'b0;
        no_mismatch();
        chk("R6", "both: excited", excited, 1);
        chk("R5", "both: observed", observed, 1);
        chk("R9", "both: exc stamp", exc_cycle, 2);
        chk("R9", "both: obs stamp", obs_cycle, 2);
    endtask

    task automatic t_masked();
        ra = 1'b0;
        rc = 1'b0;
        new_run(3'd3);
        rend = 1'b1;
        tick();
        rend = 1'b0;
        chk("R10", "no excite, not masked", masked, 0);
        rc = 1'b1;
        tick();
        rc = 1'b0;
        idle(2);
        rend = 1'b1;
        tick();
        rend = 1'b0;
        chk("R10", "excited unobserved masked", masked, 1);
        idle(2);
        chk("R10", "masked held", masked, 1);
        new_run(3'd3);
        chk("R10", "masked cleared", masked, 0);
        rc   = 1'b1;
        rend = 1'b1;
        bad  = 4'h2;
        tick();
        rend = 1'b0;
        rc   = 1'b0;
        no_mismatch();
        chk("R10", "observed same cycle not masked", masked, 0);
        new_run(3'd3);
        rc   = 1'b1;
        rend = 1'b1;
        tick();
        rend = 1'b0;
        rc   = 1'b0;
        chk("R10", "excited at run end masked", masked, 1);
    endtask

    initial begin
        rst  = 1'b1;
        clr  = 1'b0;
        rend = 1'b0;
        kind = 3'd7;
        tgt  = 4'h0;
        vec  = 4'h0;
        ra   = 1'b0;
        rc   = 1'b0;
        no_mismatch();
        idle(3);
        rst = 1'b0;
        tick();
        t_reset();
        t_lut();
        t_stuck();
        t_bridge();
        t_wired();
        t_observe_sticky();
        t_clear_collide();
        t_same_cycle();
        t_masked();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule